// File: doc/BRIEF.md
# Timestamp-Aware Read Miss Combining Table

This block keeps track of the read misses that a private cache has outstanding toward the shared cache level. The private cache keeps coherence with logical timestamps. Each warp carries a timestamp. Each returned copy carries a lease, which is a write timestamp and a read timestamp. Only one read per cache block may be in flight toward the shared level. A later read to the same block from another warp is parked in the entry that already exists, and no second request goes out.

A fill or renewal response names an entry by its tag. The entry then releases, one per cycle, every parked warp whose timestamp is at or below the returned read timestamp. The grant reports the warp's timestamp raised to at least the returned write timestamp. Warps that the lease does not cover stay parked. The entry then sends one renewal on their behalf, carrying the returned write timestamp and the largest timestamp among the warps still waiting. The entry is freed once no warp remains in it. When no entry is free for a new block, or the matching entry has no free slot, new reads are held off with a ready signal. Data storage and tag lookup live outside this block.

Top module: `mct_table`

## Requirements
- R1: After reset, out_valid_o and grant_valid_o are low, and req_ready_o is high.
- R2: A read to a block that has no entry is taken into the lowest-numbered free entry. That entry issues one request with the following fields:
  - out_tag_o: the entry number.
  - out_addr_o: the block address.
  - out_wts_o: the requester's held write timestamp, where 0 means no copy is held.
  - out_ts_o: the largest timestamp among the warps parked in the entry at the moment of issue.
  Once raised, out_valid_o stays high until out_ready_i accepts it.
- R3: A read to a block that already has an entry is parked in that entry and causes no further request. At no time do two entries hold the same block.
- R4: After a response for an entry (rsp_tag_i, rsp_wts_i, rsp_rts_i, with rsp_wts_i <= rsp_rts_i), a parked warp is granted only if its timestamp is <= rsp_rts_i. The timestamp reported on grant_ts_o is the larger of the warp's timestamp and rsp_wts_i.
- R5: At most one grant is made per cycle. The order of grants is as follows:
  - The lowest-numbered entry with a covered warp goes first.
  - Inside that entry, the lowest slot goes first. A warp is parked in the lowest free slot, and the allocating read takes slot 0.
  - grant_tag_o names the entry.
- R6: Once no parked warp is covered, if warps remain, the entry issues a renewal with these fields:
  - the same tag and address;
  - out_wts_o equal to the returned write timestamp;
  - out_ts_o equal to the largest remaining timestamp.
- R7: An entry with no parked warp left becomes free, and its number is reused by a later miss.
- R8: req_ready_o is low when the block has an entry whose slots are all in use. It is also low when the block has no entry and every entry is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp read miss offered |
| req_ready_o | output | 1 | Miss accepted this cycle |
| req_warp_i | input | WARP_W | Requesting warp id |
| req_ts_i | input | TS_W | Requesting warp timestamp |
| req_addr_i | input | ADDR_W | Block address |
| req_wts_i | input | TS_W | Write timestamp of held copy, 0 if none |
| out_valid_o | output | 1 | Request to shared level valid |
| out_ready_i | input | 1 | Shared level accepts request |
| out_tag_o | output | TAG_W | Entry number |
| out_addr_o | output | ADDR_W | Block address of request |
| out_wts_o | output | TS_W | Write timestamp carried by request |
| out_ts_o | output | TS_W | Warp timestamp carried by request |
| rsp_valid_i | input | 1 | Fill or renewal response |
| rsp_tag_i | input | TAG_W | Entry the response belongs to |
| rsp_wts_i | input | TS_W | Returned write timestamp |
| rsp_rts_i | input | TS_W | Returned read timestamp (lease end) |
| grant_valid_o | output | 1 | A parked warp is released |
| grant_tag_o | output | TAG_W | Entry of the released warp |
| grant_warp_o | output | WARP_W | Released warp id |
| grant_ts_o | output | TS_W | Updated warp timestamp |

## Verification
The bench drives five input patterns:
- A lone miss, which separates a correct allocation from a wrong request field.
- Three warps merged on one block with a lease that covers only two of them. This pattern tells a covered warp from an uncovered one, and it checks both the grant order and the content of the follow-up renewal.
- A lease that covers none of the parked warps, which must cause no grant and an immediate renewal.
- A filled table and a filled entry, which must raise backpressure and then release it as entries drain.
- A final miss after the drain, which shows that a freed entry number is reused.

A behavioural model compares ready, request and grant on every cycle. Counts of requests and grants per pattern show that merged reads never cause a second request.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SERVE = 2'd3
  } ent_state_e;
endpackage

// File: rtl/mct_pick.sv
// Lowest-index one-hot pick.
module mct_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mct_entry.sv
module mct_entry
  import mct_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int WARP_W = 5,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic [WARP_W-1:0] req_warp_i,
  input  logic [TS_W-1:0]   req_ts_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TS_W-1:0]   req_wts_i,
  input  logic              send_ack_i,
  input  logic              rsp_hit_i,
  input  logic [TS_W-1:0]   rsp_wts_i,
  input  logic [TS_W-1:0]   rsp_rts_i,
  input  logic              grant_ack_i,
  output logic              busy_o,
  output logic              match_o,
  output logic              slot_free_o,
  output logic              send_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TS_W-1:0]   send_wts_o,
  output logic [TS_W-1:0]   send_ts_o,
  output logic              serve_o,
  output logic [WARP_W-1:0] grant_warp_o,
  output logic [TS_W-1:0]   grant_ts_o
);
  ent_state_e                     state_q;
  logic [ADDR_W-1:0]              addr_q;
  logic [TS_W-1:0]                wts_q, rts_q;
  logic [N_SLOT-1:0]              sv_q;
  logic [N_SLOT-1:0][WARP_W-1:0]  sw_q;
  logic [N_SLOT-1:0][TS_W-1:0]    sts_q;

  logic [N_SLOT-1:0] cov, cov_oh, free_oh;
  logic              any_cov, any_free;
  logic [TS_W-1:0]   max_ts, g_ts_raw;
  logic [WARP_W-1:0] g_warp;

  // covered: parked and inside the returned lease
  always_comb begin
    for (int s = 0; s < N_SLOT; s++)
      cov[s] = sv_q[s] && (sts_q[s] <= rts_q) && (state_q == ST_SERVE);
  end

  mct_pick #(.N(N_SLOT)) i_cov_pick  (.req_i(cov),   .gnt_o(cov_oh),  .any_o(any_cov));
  mct_pick #(.N(N_SLOT)) i_free_pick (.req_i(~sv_q), .gnt_o(free_oh), .any_o(any_free));

  always_comb begin
    max_ts   = '0;
    g_ts_raw = '0;
    g_warp   = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (sv_q[s] && (sts_q[s] > max_ts)) max_ts = sts_q[s];
      if (cov_oh[s]) begin
        g_ts_raw = g_ts_raw | sts_q[s];
        g_warp   = g_warp | sw_q[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      addr_q  <= '0;
      wts_q   <= '0;
      rts_q   <= '0;
      sv_q    <= '0;
      sw_q    <= '0;
      sts_q   <= '0;
    end else if (alloc_i) begin
      state_q  <= ST_SEND;
      addr_q   <= req_addr_i;
      wts_q    <= req_wts_i;
      sv_q     <= N_SLOT'(1);
      sw_q[0]  <= req_warp_i;
      sts_q[0] <= req_ts_i;
    end else begin
      unique case (state_q)
        ST_SEND:  if (send_ack_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_hit_i) begin
            state_q <= ST_SERVE;
            wts_q   <= rsp_wts_i;
            rts_q   <= rsp_rts_i;
          end
        end
        ST_SERVE: begin
          // nothing covered left: renew for the rest, or retire
          if (!any_cov) state_q <= ((|sv_q) || merge_i) ? ST_SEND : ST_FREE;
        end
        default: ;
      endcase
      for (int s = 0; s < N_SLOT; s++) begin
        if (grant_ack_i && cov_oh[s]) sv_q[s] <= 1'b0;
        if (merge_i && free_oh[s]) begin
          sv_q[s]  <= 1'b1;
          sw_q[s]  <= req_warp_i;
          sts_q[s] <= req_ts_i;
        end
      end
    end
  end

  assign busy_o       = (state_q != ST_FREE);
  assign match_o      = busy_o && (addr_q == req_addr_i);
  assign slot_free_o  = any_free;
  assign send_o       = (state_q == ST_SEND);
  assign addr_o       = addr_q;
  assign send_wts_o   = wts_q;
  assign send_ts_o    = max_ts;
  assign serve_o      = any_cov;
  assign grant_warp_o = g_warp;
  assign grant_ts_o   = (g_ts_raw > wts_q) ? g_ts_raw : wts_q;
endmodule

// File: rtl/mct_table.sv
module mct_table #(
  parameter int N_ENTRY = 4,
  parameter int N_SLOT  = 4,
  parameter int WARP_W  = 5,
  parameter int TS_W    = 16,
  parameter int ADDR_W  = 24,
  localparam int TAG_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WARP_W-1:0] req_warp_i,
  input  logic [TS_W-1:0]   req_ts_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TS_W-1:0]   req_wts_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [TS_W-1:0]   out_wts_o,
  output logic [TS_W-1:0]   out_ts_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [TS_W-1:0]   rsp_wts_i,
  input  logic [TS_W-1:0]   rsp_rts_i,
  output logic              grant_valid_o,
  output logic [TAG_W-1:0]  grant_tag_o,
  output logic [WARP_W-1:0] grant_warp_o,
  output logic [TS_W-1:0]   grant_ts_o
);
  logic [N_ENTRY-1:0]             ent_busy, ent_match, ent_slot_free, ent_send, ent_serve;
  logic [N_ENTRY-1:0]             alloc_vec, merge_vec, ack_vec, rsp_hit, free_oh, send_oh, grant_oh;
  logic [N_ENTRY-1:0][ADDR_W-1:0] ent_addr;
  logic [N_ENTRY-1:0][TS_W-1:0]   ent_swts, ent_sts, ent_gts;
  logic [N_ENTRY-1:0][WARP_W-1:0] ent_gwarp;
  logic                           hit, any_free, any_send, any_grant, accept;

  assign hit         = |ent_match;
  assign req_ready_o = hit ? |(ent_match & ent_slot_free) : any_free;
  assign accept      = req_valid_i && req_ready_o;
  assign alloc_vec   = free_oh & {N_ENTRY{accept && !hit}};
  assign merge_vec   = ent_match & {N_ENTRY{accept && hit}};
  assign ack_vec     = send_oh & {N_ENTRY{out_ready_i}};

  always_comb begin
    rsp_hit = '0;
    if (rsp_valid_i) rsp_hit[rsp_tag_i] = 1'b1;
  end

  mct_pick #(.N(N_ENTRY)) i_free_pick  (.req_i(~ent_busy), .gnt_o(free_oh),  .any_o(any_free));
  mct_pick #(.N(N_ENTRY)) i_send_pick  (.req_i(ent_send),  .gnt_o(send_oh),  .any_o(any_send));
  mct_pick #(.N(N_ENTRY)) i_grant_pick (.req_i(ent_serve), .gnt_o(grant_oh), .any_o(any_grant));

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    mct_entry #(
      .N_SLOT(N_SLOT), .WARP_W(WARP_W), .TS_W(TS_W), .ADDR_W(ADDR_W)
    ) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc_vec[e]),
      .merge_i      (merge_vec[e]),
      .req_warp_i   (req_warp_i),
      .req_ts_i     (req_ts_i),
      .req_addr_i   (req_addr_i),
      .req_wts_i    (req_wts_i),
      .send_ack_i   (ack_vec[e]),
      .rsp_hit_i    (rsp_hit[e]),
      .rsp_wts_i    (rsp_wts_i),
      .rsp_rts_i    (rsp_rts_i),
      .grant_ack_i  (grant_oh[e]),
      .busy_o       (ent_busy[e]),
      .match_o      (ent_match[e]),
      .slot_free_o  (ent_slot_free[e]),
      .send_o       (ent_send[e]),
      .addr_o       (ent_addr[e]),
      .send_wts_o   (ent_swts[e]),
      .send_ts_o    (ent_sts[e]),
      .serve_o      (ent_serve[e]),
      .grant_warp_o (ent_gwarp[e]),
      .grant_ts_o   (ent_gts[e])
    );
  end

  always_comb begin
    out_tag_o   = '0;
    grant_tag_o = '0;
    for (int e = 0; e < N_ENTRY; e++) begin
      if (send_oh[e])  out_tag_o   = TAG_W'(e);
      if (grant_oh[e]) grant_tag_o = TAG_W'(e);
    end
  end

  assign out_valid_o   = any_send;
  assign out_addr_o    = ent_addr[out_tag_o];
  assign out_wts_o     = ent_swts[out_tag_o];
  assign out_ts_o      = ent_sts[out_tag_o];
  assign grant_valid_o = any_grant;
  assign grant_warp_o  = ent_gwarp[grant_tag_o];
  assign grant_ts_o    = ent_gts[grant_tag_o];
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int N_ENTRY = 4,
  parameter int TS_W    = 16,
  parameter int ADDR_W  = 24,
  parameter int TAG_W   = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_ready_i,
  input logic [N_ENTRY-1:0]             busy_i,
  input logic [N_ENTRY-1:0]             match_i,
  input logic [N_ENTRY-1:0][ADDR_W-1:0] addr_i,
  input logic                           out_valid_i,
  input logic                           out_ready_i,
  input logic                           rsp_valid_i,
  input logic [TAG_W-1:0]               rsp_tag_i,
  input logic [TS_W-1:0]                rsp_wts_i,
  input logic [TS_W-1:0]                rsp_rts_i,
  input logic                           grant_valid_i,
  input logic [TAG_W-1:0]               grant_tag_i,
  input logic [TS_W-1:0]                grant_ts_i
);
  logic [N_ENTRY-1:0][TS_W-1:0] lease_rts_q, lease_wts_q;
  logic                         dup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lease_rts_q <= '0;
      lease_wts_q <= '0;
    end else if (rsp_valid_i) begin
      lease_rts_q[rsp_tag_i] <= rsp_rts_i;
      lease_wts_q[rsp_tag_i] <= rsp_wts_i;
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N_ENTRY; i++)
      for (int j = i + 1; j < N_ENTRY; j++)
        if (busy_i[i] && busy_i[j] && (addr_i[i] == addr_i[j])) dup = 1'b1;
  end

  p_one_per_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);

  p_grant_in_lease_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_i |-> (grant_ts_i <= lease_rts_q[grant_tag_i]));

  p_grant_ts_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_i |-> (grant_ts_i >= lease_wts_q[grant_tag_i]));

  p_full_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&busy_i) && !(|match_i)) |-> !req_ready_i);

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> out_valid_i);
endmodule

bind mct_table mct_checker #(
  .N_ENTRY(N_ENTRY), .TS_W(TS_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
) i_mct_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_i  (req_ready_o),
  .busy_i       (ent_busy),
  .match_i      (ent_match),
  .addr_i       (ent_addr),
  .out_valid_i  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .rsp_valid_i  (rsp_valid_i),
  .rsp_tag_i    (rsp_tag_i),
  .rsp_wts_i    (rsp_wts_i),
  .rsp_rts_i    (rsp_rts_i),
  .grant_valid_i(grant_valid_o),
  .grant_tag_i  (grant_tag_o),
  .grant_ts_i   (grant_ts_o)
);

// File: tb/test_mct_table.sv
module test_mct_table;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4, NS = 4, WW = 5, TW = 16, AW = 24, GW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, out_ready = 1'b0, rsp_valid = 1'b0;
  logic [WW-1:0] req_warp = '0;
  logic [TW-1:0] req_ts = '0, req_wts = '0, rsp_wts = '0, rsp_rts = '0;
  logic [AW-1:0] req_addr = '0;
  logic [GW-1:0] rsp_tag = '0;
  logic req_ready_o, out_valid_o, grant_valid_o;
  logic [GW-1:0] out_tag_o, grant_tag_o;
  logic [AW-1:0] out_addr_o;
  logic [TW-1:0] out_wts_o, out_ts_o, grant_ts_o;
  logic [WW-1:0] grant_warp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mct_table #(.N_ENTRY(NE), .N_SLOT(NS), .WARP_W(WW), .TS_W(TW), .ADDR_W(AW)) i_mct_table (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_warp_i(req_warp),
    .req_ts_i(req_ts), .req_addr_i(req_addr), .req_wts_i(req_wts),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_tag_o(out_tag_o),
    .out_addr_o(out_addr_o), .out_wts_o(out_wts_o), .out_ts_o(out_ts_o),
    .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .rsp_wts_i(rsp_wts), .rsp_rts_i(rsp_rts),
    .grant_valid_o(grant_valid_o), .grant_tag_o(grant_tag_o),
    .grant_warp_o(grant_warp_o), .grant_ts_o(grant_ts_o)
  );

  int n_chk = 0, n_fail = 0, n_grant = 0, n_out = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model: 0 free, 1 to send, 2 waiting, 3 serving
  int            ms[NE], n_ms[NE];
  bit            mren[NE], n_mren[NE];
  logic [AW-1:0] ma[NE], n_ma[NE];
  logic [TW-1:0] mw[NE], n_mw[NE], mr[NE], n_mr[NE];
  bit            mv[NE][NS], n_mv[NE][NS];
  logic [WW-1:0] mwp[NE][NS], n_mwp[NE][NS];
  logic [TW-1:0] mts[NE][NS], n_mts[NE][NS];
  bit            has_cov[NE];
  int            mi, oe, ge, gs, fs;
  bit            e_ready, acc, anyv;
  logic [TW-1:0] e_ts;

  always begin
    @(negedge clk); #2;
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        ms[e] = 0; mren[e] = 0;
        for (int s = 0; s < NS; s++) mv[e][s] = 0;
      end
    end else begin
      mi = -1;
      for (int e = 0; e < NE; e++) if (ms[e] != 0 && ma[e] == req_addr) mi = e;
      e_ready = 0;
      if (mi >= 0) begin
        for (int s = 0; s < NS; s++) if (!mv[mi][s]) e_ready = 1;
      end else begin
        for (int e = 0; e < NE; e++) if (ms[e] == 0) e_ready = 1;
      end
      chk(req_ready_o == e_ready, "R8", "req_ready", int'(req_ready_o), int'(e_ready));

      oe = -1;
      for (int e = NE - 1; e >= 0; e--) if (ms[e] == 1) oe = e;
      chk(out_valid_o == (oe >= 0), (oe >= 0 && mren[oe]) ? "R6" : "R2", "out_valid",
          int'(out_valid_o), int'(oe >= 0));
      if (oe >= 0 && out_valid_o) begin
        e_ts = '0;
        for (int s = 0; s < NS; s++) if (mv[oe][s] && mts[oe][s] > e_ts) e_ts = mts[oe][s];
        chk(int'(out_tag_o) == oe, mren[oe] ? "R6" : "R2", "out_tag", int'(out_tag_o), oe);
        chk(out_addr_o == ma[oe], mren[oe] ? "R6" : "R2", "out_addr", int'(out_addr_o), int'(ma[oe]));
        chk(out_wts_o == mw[oe], mren[oe] ? "R6" : "R2", "out_wts", int'(out_wts_o), int'(mw[oe]));
        chk(out_ts_o == e_ts, mren[oe] ? "R6" : "R2", "out_ts", int'(out_ts_o), int'(e_ts));
      end

      ge = -1; gs = -1;
      for (int e = NE - 1; e >= 0; e--) begin
        has_cov[e] = 0;
        fs = -1;
        if (ms[e] == 3)
          for (int s = NS - 1; s >= 0; s--)
            if (mv[e][s] && mts[e][s] <= mr[e]) begin has_cov[e] = 1; fs = s; end
        if (has_cov[e]) begin ge = e; gs = fs; end
      end
      chk(grant_valid_o == (ge >= 0), "R4", "grant_valid", int'(grant_valid_o), int'(ge >= 0));
      if (ge >= 0 && grant_valid_o) begin
        e_ts = (mts[ge][gs] > mw[ge]) ? mts[ge][gs] : mw[ge];
        chk(int'(grant_tag_o) == ge, "R5", "grant_tag", int'(grant_tag_o), ge);
        chk(grant_warp_o == mwp[ge][gs], "R5", "grant_warp", int'(grant_warp_o), int'(mwp[ge][gs]));
        chk(grant_ts_o == e_ts, "R4", "grant_ts", int'(grant_ts_o), int'(e_ts));
      end
      if (grant_valid_o) n_grant++;
      if (out_valid_o && out_ready) n_out++;

      n_ms = ms; n_mren = mren; n_ma = ma; n_mw = mw; n_mr = mr;
      n_mv = mv; n_mwp = mwp; n_mts = mts;
      acc = req_valid && e_ready;
      for (int e = 0; e < NE; e++) begin
        if (ms[e] == 1 && e == oe && out_ready) n_ms[e] = 2;
        if (ms[e] == 2 && rsp_valid && int'(rsp_tag) == e) begin
          n_ms[e] = 3; n_mw[e] = rsp_wts; n_mr[e] = rsp_rts;
        end
        if (ms[e] == 3 && !has_cov[e]) begin
          anyv = 0;
          for (int s = 0; s < NS; s++) anyv |= mv[e][s];
          if (anyv || (acc && mi == e)) begin n_ms[e] = 1; n_mren[e] = 1; end
          else n_ms[e] = 0;
        end
      end
      if (ge >= 0) n_mv[ge][gs] = 0;
      if (acc) begin
        if (mi >= 0) begin
          fs = -1;
          for (int s = NS - 1; s >= 0; s--) if (!mv[mi][s]) fs = s;
          n_mv[mi][fs] = 1; n_mwp[mi][fs] = req_warp; n_mts[mi][fs] = req_ts;
        end else begin
          fs = -1;
          for (int e = NE - 1; e >= 0; e--) if (ms[e] == 0) fs = e;
          n_ms[fs] = 1; n_ma[fs] = req_addr; n_mw[fs] = req_wts; n_mren[fs] = 0;
          for (int s = 0; s < NS; s++) n_mv[fs][s] = 0;
          n_mv[fs][0] = 1; n_mwp[fs][0] = req_warp; n_mts[fs][0] = req_ts;
        end
      end
      @(posedge clk);
      ms = n_ms; mren = n_mren; ma = n_ma; mw = n_mw; mr = n_mr;
      mv = n_mv; mwp = n_mwp; mts = n_mts;
    end
  end

  task automatic send_req(input logic [WW-1:0] w, input logic [TW-1:0] ts,
                          input logic [AW-1:0] a, input logic [TW-1:0] wt);
    @(negedge clk);
    req_valid = 1'b1; req_warp = w; req_ts = ts; req_addr = a; req_wts = wt;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_out(output int tag);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    while (!out_valid_o) begin @(negedge clk); #1; end
    tag = int'(out_tag_o);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic respond(input int tag, input logic [TW-1:0] w, input logic [TW-1:0] r);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = GW'(tag); rsp_wts = w; rsp_rts = r;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    int tag, g0, o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    chk(out_valid_o == 1'b0, "R1", "out_valid", int'(out_valid_o), 0);
    chk(grant_valid_o == 1'b0, "R1", "grant_valid", int'(grant_valid_o), 0);
    chk(req_ready_o == 1'b1, "R1", "req_ready", int'(req_ready_o), 1);

    // lone miss
    g0 = n_grant; o0 = n_out;
    send_req(5'd1, 16'd5, 24'h000100, 16'd0);
    wait_out(tag);
    chk(tag == 0, "R2", "first tag", tag, 0);
    respond(tag, 16'd3, 16'd10);
    idle(4);
    chk(n_grant - g0 == 1, "R4", "grants lone", n_grant - g0, 1);
    chk(n_out - o0 == 1, "R2", "requests lone", n_out - o0, 1);

    // three merged warps, lease covers two, then renewal
    g0 = n_grant; o0 = n_out;
    send_req(5'd2, 16'd4, 24'h000200, 16'd0);
    send_req(5'd3, 16'd12, 24'h000200, 16'd0);
    send_req(5'd4, 16'd8, 24'h000200, 16'd0);
    wait_out(tag);
    respond(tag, 16'd7, 16'd9);
    idle(5);
    chk(n_grant - g0 == 2, "R4", "grants partial lease", n_grant - g0, 2);
    wait_out(tag);
    respond(tag, 16'd7, 16'd20);
    idle(4);
    chk(n_grant - g0 == 3, "R6", "grants after renewal", n_grant - g0, 3);
    chk(n_out - o0 == 2, "R3", "requests merged block", n_out - o0, 2);

    // lease covers nobody
    g0 = n_grant; o0 = n_out;
    send_req(5'd5, 16'd50, 24'h000300, 16'd9);
    wait_out(tag);
    respond(tag, 16'd9, 16'd20);
    idle(4);
    chk(n_grant - g0 == 0, "R4", "grants uncovered", n_grant - g0, 0);
    wait_out(tag);
    respond(tag, 16'd9, 16'd60);
    idle(4);
    chk(n_grant - g0 == 1, "R6", "grants uncovered renewed", n_grant - g0, 1);

    // fill table, then fill one entry
    g0 = n_grant;
    for (int i = 0; i < NE; i++) send_req(WW'(6 + i), 16'd2, AW'(24'h001000 + i), 16'd0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h00F000; req_warp = 5'd20; req_ts = 16'd1; req_wts = 16'd0;
    #1;
    chk(req_ready_o == 1'b0, "R8", "table full", int'(req_ready_o), 0);
    idle(2); #1;
    chk(req_ready_o == 1'b0, "R8", "table full held", int'(req_ready_o), 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NS - 1; i++) send_req(WW'(10 + i), 16'd3, 24'h001000, 16'd0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h001000; req_warp = 5'd21; req_ts = 16'd3;
    #1;
    chk(req_ready_o == 1'b0, "R8", "slots full", int'(req_ready_o), 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NE; i++) begin
      wait_out(tag);
      respond(tag, 16'd1, 16'd100);
    end
    idle(8);
    chk(n_grant - g0 == NE + NS - 1, "R5", "grants drained", n_grant - g0, NE + NS - 1);

    // freed entry reused
    #1;
    chk(req_ready_o == 1'b1, "R7", "ready after drain", int'(req_ready_o), 1);
    send_req(5'd22, 16'd4, 24'h002000, 16'd0);
    wait_out(tag);
    chk(tag == 0, "R7", "reused tag", tag, 0);
    respond(tag, 16'd2, 16'd8);
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule